// File: doc/BRIEF.md
# Front-end ASIC readout sequencer

This block steers a multi-channel front-end ASIC through one event cycle: waiting for a trigger, on-chip analog-to-digital conversion, and serial readout of the results. While idle it keeps the ASIC in acquisition mode and holds the converter in reset. A trigger from the ASIC makes the sequencer raise hold on the shared hold/clock line, switch the ASIC to conversion mode, release the converter reset after a settle time, and then toggle the same line as the conversion clock. Conversion ends when the ASIC reports done or after a fixed count of conversion clock periods, whichever comes first. The block then switches to readout mode and toggles the line as the readout clock, shifting in the serial data to build one parallel word. Afterwards it returns to acquisition.

Every delay and clock period is a parameter in system-clock cycles. At a 100 MHz system clock the defaults give a 110 ns settle time, a 150 ns lead to the first conversion edge, a 100 ns conversion clock, a 1024-period conversion limit and a 650 ns readout clock. A status output records whether the last conversion ended by timeout.

Top module: `fe_readout_seq`

## Requirements
- R1: Once reset is released, mode_o is 0 (acquisition), adc_rst_o is 1, and hold_clk_o, done_en_o, word_vld_o, conv_tmo_o and word_o are all 0. Mode codes are 0 acquisition, 1 conversion, 2 readout. adc_rst_o is 1 in every cycle where mode_o is 0.
- R2: If trig_i is sampled high in acquisition, hold_clk_o goes high in the next cycle. It stays high for HOLD_CYC cycles with mode_o still 0. After that, mode_o becomes 1 and hold_clk_o stays high.
- R3: adc_rst_o stays high for SETTLE_CYC cycles after mode_o becomes 1, then falls. hold_clk_o falls in the same cycle. The default is 11 cycles, and the value must be at least 10.
- R4: The first conversion clock high phase starts LEAD_CYC cycles after adc_rst_o falls (the default is 15, and the value must lie between 10 and 20). The clock then repeats with a period of CONV_PER cycles. Each period starts with CONV_PER/2 high cycles.
- R5: done_en_o is 1 exactly in the cycles where mode_o is 1.
- R6: If done_i is sampled high during conversion clocking, mode_o changes to 2 in the next cycle, and conv_tmo_o is then 0.
- R7: Without done_i, readout starts right after CONV_MAX complete conversion periods, and conv_tmo_o is then 1. If done_i arrives in the last cycle of the last period, it takes precedence and conv_tmo_o is 0.
- R8: In readout, mode_o is 2, adc_rst_o is 0 and hold_clk_o starts low. Each bit takes RD_PER cycles: RD_PER-RD_PER/2 low cycles followed by RD_PER/2 high cycles. sdata_i is sampled in the last cycle of each bit, and the first bit becomes the MSB of the word.
- R9: After RD_BITS bits, mode_o returns to 0 and adc_rst_o to 1. In that same first cycle, word_vld_o is high for exactly one cycle and word_o holds the assembled word. word_o keeps that value until the next word.
- R10: trig_i has no effect outside acquisition, and done_i has no effect outside conversion clocking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized on release |
| trig_i | input | 1 | Trigger from the ASIC |
| done_i | input | 1 | Conversion-complete flag from the ASIC |
| sdata_i | input | 1 | Serial readout data from the ASIC |
| mode_o | output | 2 | ASIC mode select: 0 acquisition, 1 conversion, 2 readout |
| hold_clk_o | output | 1 | Shared hold / conversion clock / readout clock line |
| adc_rst_o | output | 1 | Converter reset, high keeps the ADC at reset values |
| done_en_o | output | 1 | Enables the ASIC's done-flag output |
| word_o | output | RD_BITS | Last assembled readout word |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |
| conv_tmo_o | output | 1 | Last conversion ended by cycle limit, not by done |

## Verification
Assertions check the following on every cycle:
- the converter reset stays high throughout acquisition;
- done-enable is active exactly in conversion mode;
- the reset falls only while conversion mode is latched;
- the line is low on entry to readout;
- the word strobe lasts one cycle;
- the counters stay in range.

Only the bench's scenarios can show the exact timing. These are the cycle positions of hold, settle, lead and each clock edge; the conversion length for a done flag arriving in every possible cycle; the timeout boundary; the MSB-first word contents; and the fact that stray triggers and done flags change nothing.

// File: rtl/fe_seq_pkg.sv
package fe_seq_pkg;

  typedef enum logic [2:0] {
    ST_ACQ    = 3'd0,
    ST_HOLD   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_LEAD   = 3'd3,
    ST_CONV   = 3'd4,
    ST_READ   = 3'd5
  } seq_state_t;

  localparam logic [1:0] MODE_ACQ  = 2'd0;
  localparam logic [1:0] MODE_CONV = 2'd1;
  localparam logic [1:0] MODE_READ = 2'd2;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fe_seq_rst_sync.sv
module fe_seq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/fe_seq_timer.sv
module fe_seq_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_nxt;
  logic         cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load | ~expired;

  always_comb begin
    if (load) cnt_nxt = ld_val;
    else      cnt_nxt = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  // a spent timer parks at zero until reloaded (delays of R2/R3/R4)
  assert_tmr_parks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired);

endmodule

// File: rtl/fe_seq_phase.sv
module fe_seq_phase #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] last,
  output logic [W-1:0] ph_nxt,
  output logic         wrap
);
  logic [W-1:0] ph_q;
  logic         ph_en;

  assign wrap  = run & (ph_q == last);
  assign ph_en = clr | run;

  always_comb begin
    if (clr)       ph_nxt = '0;
    else if (!run) ph_nxt = ph_q;
    else if (wrap) ph_nxt = '0;
    else           ph_nxt = ph_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_nxt;
  end

  // clock phase never runs past the selected period (R4, R8)
  assert_phase_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ph_q <= last));

endmodule

// File: rtl/fe_seq_tally.sv
module fe_seq_tally #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  assign q_en  = clr | inc;
  assign q_nxt = clr ? '0 : (q + W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/fe_seq_deser.sv
module fe_seq_deser #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         finish,
  input  logic         sdin,
  output logic [N-1:0] word_q,
  output logic         vld_q
);
  logic [N-1:0] word_nxt;
  logic         commit;

  assign commit = shift & finish;

  generate
    if (N == 1) begin : g_single
      assign word_nxt = sdin;
    end else begin : g_multi
      logic [N-2:0] sh_q;
      assign word_nxt = {sh_q, sdin};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '0;
        else if (shift) sh_q <= word_nxt[N-2:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (commit) word_q <= word_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= commit;
  end

  assert_vld_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  assert_word_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(word_q));

endmodule

// File: rtl/fe_readout_seq.sv
module fe_readout_seq
  import fe_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYC   = 4,
  parameter int unsigned SETTLE_CYC = 11,
  parameter int unsigned LEAD_CYC   = 15,
  parameter int unsigned CONV_PER   = 10,
  parameter int unsigned CONV_MAX   = 1024,
  parameter int unsigned RD_PER     = 65,
  parameter int unsigned RD_BITS    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_i,
  input  logic               done_i,
  input  logic               sdata_i,
  output logic [1:0]         mode_o,
  output logic               hold_clk_o,
  output logic               adc_rst_o,
  output logic               done_en_o,
  output logic [RD_BITS-1:0] word_o,
  output logic               word_vld_o,
  output logic               conv_tmo_o
);

  localparam int unsigned TMR_MAX = umax(HOLD_CYC, umax(SETTLE_CYC, LEAD_CYC));
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned PH_MAX  = umax(CONV_PER, RD_PER);
  localparam int unsigned PH_W    = $clog2(PH_MAX + 1);
  localparam int unsigned TL_MAX  = umax(CONV_MAX, RD_BITS);
  localparam int unsigned TL_W    = $clog2(TL_MAX + 1);

  localparam logic [TMR_W-1:0] HOLD_LD   = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] LEAD_LD   = TMR_W'(LEAD_CYC - 1);
  localparam logic [PH_W-1:0]  CONV_LAST = PH_W'(CONV_PER - 1);
  localparam logic [PH_W-1:0]  CONV_HI   = PH_W'(CONV_PER / 2);
  localparam logic [PH_W-1:0]  RD_LAST   = PH_W'(RD_PER - 1);
  localparam logic [PH_W-1:0]  RD_LO     = PH_W'(RD_PER - RD_PER / 2);
  localparam logic [TL_W-1:0]  CMAX_LAST = TL_W'(CONV_MAX - 1);
  localparam logic [TL_W-1:0]  BITS_LAST = TL_W'(RD_BITS - 1);

  // ---------------------------------------------------------------
  logic srst_n;

  fe_seq_rst_sync u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  seq_state_t st_q, st_nxt;

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_done;
  logic             ph_clr, ph_run, ph_wrap;
  logic [PH_W-1:0]  ph_last, ph_nxt;
  logic             tl_clr, tl_inc;
  logic [TL_W-1:0]  tl_q;
  logic             bit_shift, bit_finish;
  logic             tmo_upd, tmo_val;

  fe_seq_timer #(.W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (tmr_load),
    .ld_val  (tmr_val),
    .expired (tmr_done)
  );

  fe_seq_phase #(.W(PH_W)) u_phase (
    .clk    (clk),
    .rst_n  (srst_n),
    .clr    (ph_clr),
    .run    (ph_run),
    .last   (ph_last),
    .ph_nxt (ph_nxt),
    .wrap   (ph_wrap)
  );

  fe_seq_tally #(.W(TL_W)) u_tally (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (tl_clr),
    .inc   (tl_inc),
    .q     (tl_q)
  );

  fe_seq_deser #(.N(RD_BITS)) u_deser (
    .clk    (clk),
    .rst_n  (srst_n),
    .shift  (bit_shift),
    .finish (bit_finish),
    .sdin   (sdata_i),
    .word_q (word_o),
    .vld_q  (word_vld_o)
  );

  // ---------------------------------------------------------------
  // next-state logic
  always_comb begin
    st_nxt     = st_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    ph_clr     = 1'b0;
    ph_run     = 1'b0;
    ph_last    = CONV_LAST;
    tl_clr     = 1'b0;
    tl_inc     = 1'b0;
    bit_shift  = 1'b0;
    bit_finish = 1'b0;
    tmo_upd    = 1'b0;
    tmo_val    = 1'b0;
    case (st_q)
      ST_ACQ: begin
        if (trig_i) begin
          st_nxt   = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LD;
        end
      end
      ST_HOLD: begin
        if (tmr_done) begin
          st_nxt   = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
        end
      end
      ST_SETTLE: begin
        if (tmr_done) begin
          st_nxt   = ST_LEAD;
          tmr_load = 1'b1;
          tmr_val  = LEAD_LD;
        end
      end
      ST_LEAD: begin
        if (tmr_done) begin
          st_nxt = ST_CONV;
          ph_clr = 1'b1;
          tl_clr = 1'b1;
        end
      end
      ST_CONV: begin
        ph_run  = 1'b1;
        ph_last = CONV_LAST;
        tl_inc  = ph_wrap;
        if (done_i) begin
          st_nxt  = ST_READ;
          ph_clr  = 1'b1;
          tl_clr  = 1'b1;
          tmo_upd = 1'b1;
          tmo_val = 1'b0;
        end else if (ph_wrap && (tl_q == CMAX_LAST)) begin
          st_nxt  = ST_READ;
          ph_clr  = 1'b1;
          tl_clr  = 1'b1;
          tmo_upd = 1'b1;
          tmo_val = 1'b1;
        end
      end
      ST_READ: begin
        ph_run    = 1'b1;
        ph_last   = RD_LAST;
        tl_inc    = ph_wrap;
        bit_shift = ph_wrap;
        if (ph_wrap && (tl_q == BITS_LAST)) begin
          bit_finish = 1'b1;
          st_nxt     = ST_ACQ;
        end
      end
      default: st_nxt = ST_ACQ;
    endcase
  end

  // ---------------------------------------------------------------
  // output values for the coming cycle, decoded from next state
  logic [1:0] mode_nxt;
  logic       hold_nxt, arst_nxt, den_nxt;

  always_comb begin
    mode_nxt = MODE_ACQ;
    hold_nxt = 1'b0;
    arst_nxt = 1'b0;
    den_nxt  = 1'b0;
    case (st_nxt)
      ST_ACQ: begin
        arst_nxt = 1'b1;
      end
      ST_HOLD: begin
        hold_nxt = 1'b1;
        arst_nxt = 1'b1;
      end
      ST_SETTLE: begin
        mode_nxt = MODE_CONV;
        hold_nxt = 1'b1;
        arst_nxt = 1'b1;
        den_nxt  = 1'b1;
      end
      ST_LEAD: begin
        mode_nxt = MODE_CONV;
        den_nxt  = 1'b1;
      end
      ST_CONV: begin
        mode_nxt = MODE_CONV;
        hold_nxt = (ph_nxt < CONV_HI);
        den_nxt  = 1'b1;
      end
      ST_READ: begin
        mode_nxt = MODE_READ;
        hold_nxt = (ph_nxt >= RD_LO);
      end
      default: arst_nxt = 1'b1;
    endcase
  end

  // ---------------------------------------------------------------
  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) st_q <= ST_ACQ;
    else         st_q <= st_nxt;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_o     <= MODE_ACQ;
      hold_clk_o <= 1'b0;
      adc_rst_o  <= 1'b1;
      done_en_o  <= 1'b0;
    end else begin
      mode_o     <= mode_nxt;
      hold_clk_o <= hold_nxt;
      adc_rst_o  <= arst_nxt;
      done_en_o  <= den_nxt;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      conv_tmo_o <= 1'b0;
    else if (tmo_upd) conv_tmo_o <= tmo_val;
  end

  // ---------------------------------------------------------------
  assert_acq_rst_high_R1: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_o == MODE_ACQ) |-> adc_rst_o);

  assert_done_en_conv_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_o == MODE_CONV) |-> done_en_o);

  assert_done_en_off_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_o != MODE_CONV) |-> !done_en_o);

  assert_rst_fall_in_conv_R3: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(adc_rst_o) |-> ((mode_o == MODE_CONV) && ($past(mode_o) == MODE_CONV)));

  assert_read_entry_low_R8: assert property (@(posedge clk) disable iff (!srst_n)
    ((mode_o == MODE_READ) && ($past(mode_o) == MODE_CONV)) |-> !hold_clk_o);

  assert_read_exit_word_R9: assert property (@(posedge clk) disable iff (!srst_n)
    ((mode_o == MODE_ACQ) && ($past(mode_o) == MODE_READ)) |-> word_vld_o);

  assert_conv_count_bound_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_CONV) |-> (tl_q <= CMAX_LAST));

endmodule

// File: tb/tb_fe_readout_seq.sv
module tb_fe_readout_seq;

  localparam int H  = 2;
  localparam int S  = 3;
  localparam int L  = 2;
  localparam int P  = 4;
  localparam int CM = 5;
  localparam int RP = 6;
  localparam int B  = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         trig, done, sdata;
  logic [1:0]   mode;
  logic         hold_clk, adc_rst, done_en, vld, tmo;
  logic [B-1:0] word;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  fe_readout_seq #(
    .HOLD_CYC(H), .SETTLE_CYC(S), .LEAD_CYC(L), .CONV_PER(P),
    .CONV_MAX(CM), .RD_PER(RP), .RD_BITS(B)
  ) dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .done_i(done), .sdata_i(sdata),
    .mode_o(mode), .hold_clk_o(hold_clk), .adc_rst_o(adc_rst), .done_en_o(done_en),
    .word_o(word), .word_vld_o(vld), .conv_tmo_o(tmo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one event: trigger, conversion ending at done cycle jd (or timeout if jd<0), readout of pat
  task automatic run(input int jd, input int pat, input bit junk);
    int c0   = H + S + L;
    int cl   = (jd >= 0) ? jd + 1 : CM * P;
    int r0   = c0 + cl;
    int rend = r0 + B * RP;
    @(negedge clk);
    trig = 1'b1; done = 1'b0; sdata = 1'b0;
    @(negedge clk);
    for (int k = 0; k <= rend + 1; k++) begin
      int em, eh, er, ed;
      string tg;
      if (k < H)            begin em = 0; eh = 1; er = 1; ed = 0; tg = "R2"; end
      else if (k < H + S)   begin em = 1; eh = 1; er = 1; ed = 1; tg = "R3"; end
      else if (k < c0)      begin em = 1; eh = 0; er = 0; ed = 1; tg = "R4"; end
      else if (k < r0)      begin em = 1; eh = (((k - c0) % P) < P / 2) ? 1 : 0; er = 0; ed = 1;
                                  tg = (jd >= 0) ? "R6" : "R7"; end
      else if (k < rend)    begin em = 2; eh = (((k - r0) % RP) >= (RP - RP / 2)) ? 1 : 0; er = 0; ed = 0;
                                  tg = "R8"; end
      else                  begin em = 0; eh = 0; er = 1; ed = 0; tg = "R9"; end
      if (junk) tg = {tg, "/R10"};
      chk({tg, " mode"},    int'(mode),     em);
      chk({tg, " hold_clk"}, int'(hold_clk), eh);
      chk({tg, " adc_rst"},  int'(adc_rst),  er);
      chk("R5 done_en",      int'(done_en),  ed);
      chk("R9 word_vld",     int'(vld),      (k == rend) ? 1 : 0);
      if (k >= rend) chk("R9 word MSB first", int'(word), pat);
      if (k == rend) chk((jd >= 0) ? "R6 conv_tmo" : "R7 conv_tmo", int'(tmo), (jd >= 0) ? 0 : 1);
      // inputs for this cycle, sampled at its closing edge
      done  = ((jd >= 0) && (k == c0 + jd)) || (junk && (k < c0));
      trig  = junk && (k < rend);
      if ((k >= r0) && (k < rend)) sdata = 1'((pat >> (B - 1 - (k - r0) / RP)) & 1);
      else                         sdata = junk;
      @(negedge clk);
    end
    trig = 1'b0; sdata = 1'b0;
    done = 1'b1;  // R10: done while idle must not start anything
    for (int i = 0; i < 3; i++) begin
      chk("R10 idle mode", int'(mode), 0);
      chk("R10 idle hold_clk", int'(hold_clk), 0);
      chk("R1 idle adc_rst", int'(adc_rst), 1);
      @(negedge clk);
    end
    done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired, run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trig = 1'b0; done = 1'b0; sdata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset hold_clk", int'(hold_clk), 0);
    chk("R1 reset adc_rst", int'(adc_rst), 1);
    chk("R1 reset done_en", int'(done_en), 0);
    chk("R1 reset word_vld", int'(vld), 0);
    chk("R1 reset conv_tmo", int'(tmo), 0);
    chk("R1 reset word", int'(word), 0);
    // done in every conversion cycle, plus the pure timeout; patterns cover all 16 words
    for (int jd = -1; jd < CM * P; jd++) run(jd, ((jd + 1) * 7) & 15, 1'b0);
    // stray trigger and done during busy phases
    run(-1, 4'hA, 1'b1);
    run(3, 4'h5, 1'b1);
    run(CM * P - 1, 4'hC, 1'b1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule